// File: doc/BRIEF.md
# Multicycle Issue Hazard Interlock

This block sits at the issue stage of an in-order pipeline whose execution resources differ in latency: a single-cycle integer unit, a pipelined adder, a pipelined multiplier and a long divider that is not pipelined. Each cycle it is offered at most one decoded instruction: the unit it needs, an optional destination register and up to two optional source registers. In that same cycle it answers issue or stall. While an instruction is stalled, the front end keeps presenting it, and nothing younger moves past it.

For every register, the interlock keeps a countdown of the cycles left before a pending result can be consumed. It keeps a busy countdown for each unit that cannot accept work every cycle. It also keeps a shift register of write-back slots that are already booked. From these it detects read-after-write and write-after-write conflicts, an occupied divider, and two results that would need the single write port in the same cycle. A synchronous flush empties all of this state at once. The execution units themselves are modelled only by their latency and initiation interval.

Top module: `fp_issue_interlock`

## Requirements
- R1: When `in_valid` is high, exactly one of `issue_o` and `stall_o` is high in that cycle. When `in_valid` is low, both are low. A stalled instruction is presented again in later cycles, and it is the only instruction that can issue until it does.
- R2: Unit codes on `in_unit`: 0 is integer (latency 0), 1 is adder (latency 3), 2 is multiplier (latency 6), 3 is divider (latency 24). The integer, adder and multiplier units have an initiation interval of 1.
- R3: Suppose an instruction of latency L issues in cycle c and writes register d. A later instruction that has an enabled source equal to d stalls in cycles c+1 to c+L and can issue in cycle c+L+1. When L is 0 it can issue in cycle c+1.
- R4: An instruction whose enabled destination matches a register that still has a pending write stalls until that write's countdown has expired. This takes L stall cycles when the instruction is presented right after an instruction of latency L.
- R5: Suppose a divide issues in cycle c. Another divide presented from cycle c+1 onward stalls until cycle c+25. Other units are not affected by the busy divider.
- R6: An instruction that has an enabled destination and would write back in cycle c+L, where that slot is already booked by an earlier issue, stalls for that cycle. Booking a slot happens only on issue.
- R7: No write-after-read check is made. An instruction whose destination is a source of an older, still running instruction issues without delay when no other hazard applies.
- R8: A source or destination with its enable low is ignored. An instruction without a destination books no write-back slot, so a slot collision cannot stall it.
- R9: While `flush` is high, no instruction issues. After one cycle of `flush`, all pending countdowns, unit busy counters and slot bookings are clear.
- R10: After reset no register is pending, no unit is busy and no slot is booked. Any instruction presented first issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all hazard state; blocks issue this cycle |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_unit | input | 2 | Unit code (see R2) |
| in_dst | input | REG_W | Destination register index |
| in_dst_en | input | 1 | Destination is written |
| in_src0 | input | REG_W | First source register index |
| in_src0_en | input | 1 | First source is read |
| in_src1 | input | REG_W | Second source register index |
| in_src1_en | input | 1 | Second source is read |
| issue_o | output | 1 | Offered instruction issues this cycle |
| stall_o | output | 1 | Offered instruction is held this cycle |

## Verification
On every cycle, the assertions check the following. Issue and stall are mutually exclusive. A per-register countdown is loaded with the issuing unit's latency and then falls by exactly one each cycle. No destination is booked while its countdown is still running. The divider is never restarted while busy, and every start reloads the full interval. A write-back slot is never booked twice. Flush empties both the countdowns and the slot ring. The exact number of stall cycles that each latency produces, the divider's 25-cycle spacing, a slot collision between the multiplier and a later adder or integer instruction, the absence of any write-after-read stall, and the suppression of issue during flush are timing outcomes. Only the directed scenarios of the bench can measure them.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

   typedef enum logic [1:0] {
      UNIT_INT = 2'd0,
      UNIT_ADD = 2'd1,
      UNIT_MUL = 2'd2,
      UNIT_DIV = 2'd3
   } unit_e;

   localparam int unsigned NUM_UNITS = 4;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/fpi_scoreboard.sv
module fpi_scoreboard #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned CNT_W    = 5,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                set_en,
   input  logic [REG_W-1:0]    set_idx,
   input  logic [CNT_W-1:0]    set_lat,
   output logic [NUM_REGS-1:0] pend_o
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [CNT_W-1:0] cnt_q;
      logic             hit;

      assign hit = set_en && (set_idx == REG_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (flush) begin
            cnt_q <= '0;
         end else if (hit) begin
            cnt_q <= set_lat;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign pend_o[i] = (cnt_q != '0);

      // R4: a destination is never re-booked while its previous write is pending
      assert_no_rebook_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && set_lat != '0) |-> (cnt_q == '0));

      // R3: a loaded countdown holds the issuing latency on the next cycle
      assert_load_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !flush) |=> (cnt_q == $past(set_lat)));

      // R3: a running countdown falls by exactly one per cycle
      assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q != '0 && !flush && !hit) |=> (cnt_q == $past(cnt_q) - 1'b1));
   end

   // R9: flush leaves no register pending
   assert_flush_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pend_o == '0));

endmodule

// File: rtl/fpi_unit_gate.sv
module fpi_unit_gate #(
   parameter int unsigned II    = 25,
   localparam int unsigned CW   = (II > 2) ? $clog2(II) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic start,
   output logic busy_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (flush) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(II - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   // R5: the unit is never started while still occupied
   assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_o);

   // R5: each start reserves the full initiation interval
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !flush) |=> (cnt_q == CW'(II - 1)));

   // R9: flush frees the unit
   assert_flush_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !busy_o);

endmodule

// File: rtl/fpi_wb_ring.sv
module fpi_wb_ring #(
   parameter int unsigned DEPTH = 25,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             book_en,
   input  logic [IDX_W-1:0] book_slot,
   output logic [DEPTH-1:0] slots_o
);

   logic [DEPTH-1:0] ring_q;
   logic [DEPTH-1:0] book_mask;
   logic [DEPTH-1:0] ring_d;

   always_comb begin
      book_mask = '0;
      if (book_en) book_mask[book_slot] = 1'b1;
      ring_d = (ring_q | book_mask) >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q <= '0;
      end else if (flush) begin
         ring_q <= '0;
      end else begin
         ring_q <= ring_d;
      end
   end

   assign slots_o = ring_q;

   // R6: a write-back slot is never booked twice
   assert_no_double_book_R6: assert property (@(posedge clk) disable iff (!rst_n)
      book_en |-> !ring_q[book_slot]);

   // R6: a booked slot advances one position per cycle
   assert_slot_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (book_en && !flush && book_slot != '0) |=> ring_q[$past(book_slot) - 1'b1]);

   // R9: flush drops every booking
   assert_flush_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ring_q == '0));

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
   import fpi_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned LAT_INT  = 0,
   parameter int unsigned LAT_ADD  = 3,
   parameter int unsigned LAT_MUL  = 6,
   parameter int unsigned LAT_DIV  = 24,
   parameter int unsigned II_INT   = 1,
   parameter int unsigned II_ADD   = 1,
   parameter int unsigned II_MUL   = 1,
   parameter int unsigned II_DIV   = 25,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   input  logic [1:0]       in_unit,
   input  logic [REG_W-1:0] in_dst,
   input  logic             in_dst_en,
   input  logic [REG_W-1:0] in_src0,
   input  logic             in_src0_en,
   input  logic [REG_W-1:0] in_src1,
   input  logic             in_src1_en,
   output logic             issue_o,
   output logic             stall_o
);

   localparam int unsigned MAX_LAT = max4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
   localparam int unsigned DEPTH   = MAX_LAT + 1;
   localparam int unsigned CNT_W   = (DEPTH > 2) ? $clog2(DEPTH) : 1;
   localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned UNIT_II [NUM_UNITS] = '{II_INT, II_ADD, II_MUL, II_DIV};

   // elaboration-time parameter checks
   if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (II_INT < 1 || II_ADD < 1 || II_MUL < 1 || II_DIV < 1) begin : g_bad_ii
      $error("every initiation interval must be at least 1");
   end
   if (IDX_W > CNT_W) begin : g_bad_width
      $error("slot index width exceeds countdown width");
   end

   // latency of the offered instruction
   logic [CNT_W-1:0] sel_lat;
   always_comb begin
      unique case (unit_e'(in_unit))
         UNIT_INT: sel_lat = CNT_W'(LAT_INT);
         UNIT_ADD: sel_lat = CNT_W'(LAT_ADD);
         UNIT_MUL: sel_lat = CNT_W'(LAT_MUL);
         default:  sel_lat = CNT_W'(LAT_DIV);
      endcase
   end

   logic [NUM_REGS-1:0]  pend;
   logic [DEPTH-1:0]     slots;
   logic [NUM_UNITS-1:0] unit_busy;
   logic [NUM_UNITS-1:0] unit_start;

   logic raw_hz, waw_hz, unit_hz, wb_hz, hazard;
   logic issue_int;

   always_comb begin
      raw_hz  = (in_src0_en && pend[in_src0]) || (in_src1_en && pend[in_src1]);
      waw_hz  = in_dst_en && pend[in_dst];
      unit_hz = unit_busy[in_unit];
      wb_hz   = in_dst_en && slots[IDX_W'(sel_lat)];
      hazard  = raw_hz || waw_hz || unit_hz || wb_hz;
   end

   assign issue_int = in_valid && !flush && !hazard;
   assign issue_o   = issue_int;
   assign stall_o   = in_valid && !issue_int;

   fpi_scoreboard #(
      .NUM_REGS (NUM_REGS),
      .CNT_W    (CNT_W)
   ) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .set_en  (issue_int && in_dst_en),
      .set_idx (in_dst),
      .set_lat (sel_lat),
      .pend_o  (pend)
   );

   fpi_wb_ring #(
      .DEPTH (DEPTH)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .book_en   (issue_int && in_dst_en),
      .book_slot (IDX_W'(sel_lat)),
      .slots_o   (slots)
   );

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign unit_start[u] = issue_int && (in_unit == 2'(u));
      if (UNIT_II[u] > 1) begin : g_gated
         fpi_unit_gate #(
            .II (UNIT_II[u])
         ) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .start  (unit_start[u]),
            .busy_o (unit_busy[u])
         );
      end else begin : g_free
         assign unit_busy[u] = 1'b0;
      end
   end

   // R1: issue and stall are exclusive and only answer an offered instruction
   assert_issue_stall_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o || stall_o) |-> (in_valid && !(issue_o && stall_o)));

   // R9: nothing issues in a flush cycle
   assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !issue_o);

endmodule

// File: tb/fp_issue_interlock_tb.sv
module fp_issue_interlock_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_unit = 2'd0;
   logic [4:0] in_dst = '0;
   logic       in_dst_en = 1'b0;
   logic [4:0] in_src0 = '0;
   logic       in_src0_en = 1'b0;
   logic [4:0] in_src1 = '0;
   logic       in_src1_en = 1'b0;
   logic       issue_o, stall_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   fp_issue_interlock u_dut (
      .clk, .rst_n, .flush, .in_valid, .in_unit, .in_dst, .in_dst_en,
      .in_src0, .in_src0_en, .in_src1, .in_src1_en, .issue_o, .stall_o
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected <20000)", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // present one instruction for one cycle (called just after a falling edge)
   task automatic cyc(input bit v, input int unit, input int dst, input bit de,
                      input int s0, input bit s0e, input int s1, input bit s1e,
                      output bit iss, output bit stl);
      in_valid = v; in_unit = 2'(unit); in_dst = 5'(dst); in_dst_en = de;
      in_src0 = 5'(s0); in_src0_en = s0e; in_src1 = 5'(s1); in_src1_en = s1e;
      #1;
      iss = issue_o; stl = stall_o;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // keep presenting until issue; returns stall cycles, flags a bad stall/issue pair
   task automatic until_issue(input int unit, input int dst, input bit de,
                              input int s0, input bit s0e, input int s1, input bit s1e,
                              output int stalls, output bit pair_ok);
      bit iss, stl;
      stalls = 0; pair_ok = 1'b1;
      for (int k = 0; k < 60; k++) begin
         cyc(1'b1, unit, dst, de, s0, s0e, s1, s1e, iss, stl);
         if (iss == stl) pair_ok = 1'b0;
         if (iss) break;
         stalls++;
      end
   endtask

   task automatic t_reset();
      bit iss, stl;
      #1;
      check(!issue_o && !stall_o, "R1 idle outputs low", int'(issue_o) + int'(stall_o), 0);
      cyc(1'b1, 3, 7, 1'b1, 7, 1'b1, 9, 1'b1, iss, stl);
      check(iss && !stl, "R10 first instruction issues after reset", int'(iss), 1);
      idle(30);
   endtask

   task automatic t_raw(input int unit, input int lat, input string tag);
      bit iss, stl, ok; int n;
      cyc(1'b1, unit, 5, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      check(iss, {tag, " producer issues"}, int'(iss), 1);
      until_issue(0, 0, 1'b0, 1, 1'b0, 5, 1'b1, n, ok);
      check(n == lat, {tag, " RAW stall cycles"}, n, lat);
      check(ok, "R1 exactly one of issue/stall while offered", int'(ok), 1);
      idle(30);
   endtask

   task automatic t_waw();
      bit iss, stl, ok; int n;
      cyc(1'b1, 2, 7, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      until_issue(0, 7, 1'b1, 0, 1'b0, 0, 1'b0, n, ok);
      check(n == 6, "R4 WAW stall after multiplier", n, 6);
      idle(30);
      cyc(1'b1, 1, 8, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      until_issue(2, 8, 1'b1, 0, 1'b0, 0, 1'b0, n, ok);
      check(n == 3, "R4 WAW stall after adder", n, 3);
      idle(30);
   endtask

   task automatic t_div();
      bit iss, stl, ok; int n;
      cyc(1'b1, 3, 1, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      cyc(1'b1, 1, 2, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      check(iss, "R5 adder unaffected by busy divider", int'(iss), 1);
      until_issue(3, 3, 1'b1, 0, 1'b0, 0, 1'b0, n, ok);
      // second divide offered from cycle c+2, issues at c+25
      check(n == 23, "R5 divider initiation interval", n, 23);
      idle(30);
   endtask

   task automatic t_wb();
      bit iss, stl, ok; int n;
      cyc(1'b1, 2, 10, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      idle(2);
      until_issue(1, 11, 1'b1, 0, 1'b0, 0, 1'b0, n, ok);
      check(n == 1, "R6 adder collides with multiplier slot", n, 1);
      idle(30);
      cyc(1'b1, 2, 12, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      idle(5);
      cyc(1'b1, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, iss, stl);
      check(iss, "R8 no-destination instruction ignores booked slot", int'(iss), 1);
      idle(30);
      cyc(1'b1, 2, 12, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      idle(5);
      until_issue(0, 13, 1'b1, 0, 1'b0, 0, 1'b0, n, ok);
      check(n == 1, "R6 integer collides with multiplier slot", n, 1);
      idle(30);
   endtask

   task automatic t_war_enables();
      bit iss, stl;
      cyc(1'b1, 3, 3, 1'b1, 4, 1'b1, 6, 1'b1, iss, stl);
      cyc(1'b1, 1, 4, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      check(iss, "R7 write to a source of older divide issues", int'(iss), 1);
      cyc(1'b1, 0, 0, 1'b0, 3, 1'b0, 3, 1'b0, iss, stl);
      check(iss, "R8 disabled sources on pending register ignored", int'(iss), 1);
      cyc(1'b1, 0, 0, 1'b0, 0, 1'b0, 3, 1'b1, iss, stl);
      check(!iss && stl, "R3 enabled second source on pending register stalls", int'(iss), 0);
      idle(30);
   endtask

   task automatic t_flush();
      bit iss, stl;
      cyc(1'b1, 2, 9, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      cyc(1'b1, 3, 8, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      flush = 1'b1;
      cyc(1'b1, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, iss, stl);
      flush = 1'b0;
      check(!iss && stl, "R9 no issue during flush", int'(iss), 0);
      cyc(1'b1, 0, 0, 1'b0, 9, 1'b1, 8, 1'b1, iss, stl);
      check(iss, "R9 pending cleared by flush", int'(iss), 1);
      cyc(1'b1, 3, 9, 1'b1, 0, 1'b0, 0, 1'b0, iss, stl);
      check(iss, "R9 divider freed by flush", int'(iss), 1);
      idle(30);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raw(0, 0, "R3 R2 integer");
      t_raw(1, 3, "R3 R2 adder");
      t_raw(2, 6, "R3 R2 multiplier");
      t_raw(3, 24, "R3 R2 divider");
      t_waw();
      t_div();
      t_wb();
      t_war_enables();
      t_flush();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule